// File: doc/BRIEF.md
# Downlink Command Frame Assembler

This block turns one reader-to-tag command for a low-frequency proximity tag into the exact bit sequence the tag expects, and hands it out one bit at a time, MSB first, to a symbol timing generator. The caller presents a control byte, a 32-bit password, 32-bit write data and a 3-bit block address, and pulses `start_i` for one cycle. The whole frame is assembled from these inputs in that cycle. The inputs are not used again after that cycle.

How the frame is built depends on the downlink mode and the command type. The leading-zero and one-of-four modes put reference bits in front of the frame and a two-bit prefix in front of the password. A reset command carries only its opcode. A read command omits the data word. A register read omits both the lock bit and the block address. Each bit is offered on a valid/ready pair. When the last bit has been taken, `done_o` pulses for one cycle. If a frame is longer than the buffer can hold, `err_o` pulses and no bit is sent.

The controller has three states. `ST_IDLE` waits for a start. The transition IDLE→SEND is taken when a start arrives and the frame fits. The transition IDLE→IDLE with an error pulse is taken when the frame does not fit. `ST_SEND` offers bits. The transition SEND→FINISH is taken when the last bit is accepted. `ST_FINISH` raises `done_o` for one cycle and always returns FINISH→IDLE.

Top module: `dlf_frame_assembler`

## Requirements
- R1: While reset is held and right after it is released, `bit_valid_o`, `done_o` and `err_o` are 0, and `frame_len_o` and `mode_o` are 0.
- R2: The control byte is decoded as follows:
  - bit 0: password enable
  - bit 1: page
  - bit 2: test
  - bits 4:3: mode (0 fixed, 1 long reference, 2 leading zero, 3 one-of-four)
  - bit 5: register read
  - bit 6: read
  - bit 7: reset

  Mode 2 starts the frame with one 0 bit and mode 3 with two 0 bits. Modes 0 and 1 add no reference bit.
- R3: A reset command (bit 7 set) sends the opcode 00 after any reference bits, and nothing else.
- R4: For a command that is not a reset, the opcode is 1 followed by the page bit. When test (bit 2) is set, the opcode is 0 followed by 1 instead.
- R5: With password enable set, the 32-bit password follows the opcode MSB first. In modes 2 and 3 it is preceded by two 0 bits.
- R6: Next comes a lock bit of 0 unless register read is set. Then come the 32 data bits, MSB first, unless read is set. Last come the 3 address bits, MSB first, unless register read is set.
- R7: From the cycle after an accepted start, `frame_len_o` equals the number of bits that will be sent and `mode_o` equals control bits 4:3. Both stay stable while bits are being sent.
- R8: While `bit_valid_o` is high and `bit_ready_i` is low, `bit_o` and `bit_valid_o` hold. A bit counts as sent only on a cycle where both are high.
- R9: `done_o` is high for exactly one cycle, the cycle right after the last bit is accepted. A start pulse while a frame is in progress is ignored.
- R10: If a frame would exceed `BUF_BITS`, `err_o` pulses in the cycle after the start and no bit is offered. With the default of 80 this never happens, because the longest frame is 74 bits.
- R11: In mode 3 bits are sent in whole pairs. An unpaired final bit is dropped, so `frame_len_o` is always even in that mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to assemble and send a frame |
| ctrl_i | input | 8 | Command control byte (fields in R2) |
| pwd_i | input | 32 | Password word |
| wdata_i | input | 32 | Write data word |
| addr_i | input | 3 | Block address |
| bit_o | output | 1 | Current frame bit |
| bit_valid_o | output | 1 | `bit_o` is valid |
| bit_ready_i | input | 1 | Downstream accepts `bit_o` |
| frame_len_o | output | LEN_W (7) | Number of bits in the current frame |
| mode_o | output | 2 | Downlink mode of the current frame |
| done_o | output | 1 | One-cycle pulse after the final bit is accepted |
| err_o | output | 1 | One-cycle pulse when a frame does not fit the buffer |

## Verification
The assertions assume that `start_i` is a single-cycle pulse and that the command inputs are valid in that cycle. They also assume that `bit_ready_i` may fall or rise on any cycle.

The bench drives each command in one cycle only. It toggles ready from a shift-register pattern so that stalls land mid-field, and it pulses a second start inside a long frame to show that the start is ignored.

A second instance with a 40-bit buffer receives the same commands. This exercises the oversize path, which the default buffer can never reach.

// File: rtl/dlf_pkg.sv
package dlf_pkg;
    // Largest frame the protocol can produce is 74 bits; buffer space rounds up.
    localparam int FRAME_MAX = 80;

    typedef enum logic [1:0] {
        DL_FIXED   = 2'd0,
        DL_LONGREF = 2'd1,
        DL_LEAD0   = 2'd2,
        DL_QUAD    = 2'd3
    } dl_mode_e;

    // Control byte, MSB first: bit7 .. bit0
    typedef struct packed {
        logic     rst_cmd;
        logic     no_data;
        logic     no_addr;
        dl_mode_e mode;
        logic     test;
        logic     page;
        logic     use_pwd;
    } dl_ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEND   = 2'd1,
        ST_FINISH = 2'd2
    } dlf_state_e;
endpackage

// File: rtl/dlf_field_packer.sv
module dlf_field_packer
    import dlf_pkg::*;
#(
    parameter  int BUF_BITS = 80,
    localparam int LEN_W    = $clog2(BUF_BITS + 1)
) (
    input  dl_ctrl_t            ctrl_i,
    input  logic [31:0]         pwd_i,
    input  logic [31:0]         wdata_i,
    input  logic [2:0]          addr_i,
    output logic [BUF_BITS-1:0] frame_o,
    output logic [LEN_W-1:0]    len_o,
    output logic                overflow_o
);
    logic [FRAME_MAX-1:0] acc;
    logic [FRAME_MAX-1:0] aligned;
    int unsigned          n;
    int unsigned          n_send;
    logic                 has_ref;

    // Shift w new bits (low bits of v) in at the bottom of the accumulator.
    function automatic logic [FRAME_MAX-1:0] append(
        input logic [FRAME_MAX-1:0] a,
        input logic [31:0]          v,
        input int unsigned          w
    );
        logic [FRAME_MAX-1:0] mask;
        logic [FRAME_MAX-1:0] ext;
        mask = ~({FRAME_MAX{1'b1}} << w);
        ext  = {{(FRAME_MAX-32){1'b0}}, v};
        return (a << w) | (ext & mask);
    endfunction

    assign has_ref = (ctrl_i.mode == DL_LEAD0) || (ctrl_i.mode == DL_QUAD);

    always_comb begin
        acc = '0;
        n   = 0;
        if (has_ref) begin
            acc = append(acc, 32'd0, 1);
            n   = n + 1;
        end
        if (ctrl_i.mode == DL_QUAD) begin
            acc = append(acc, 32'd0, 1);
            n   = n + 1;
        end
        if (ctrl_i.rst_cmd) begin
            acc = append(acc, 32'd0, 2);
            n   = n + 2;
        end else begin
            acc = append(acc, ctrl_i.test ? 32'd1 : {30'd0, 1'b1, ctrl_i.page}, 2);
            n   = n + 2;
            if (ctrl_i.use_pwd) begin
                if (has_ref) begin
                    acc = append(acc, 32'd0, 2);
                    n   = n + 2;
                end
                acc = append(acc, pwd_i, 32);
                n   = n + 32;
            end
            if (!ctrl_i.no_addr) begin
                acc = append(acc, 32'd0, 1);
                n   = n + 1;
            end
            if (!ctrl_i.no_data) begin
                acc = append(acc, wdata_i, 32);
                n   = n + 32;
            end
            if (!ctrl_i.no_addr) begin
                acc = append(acc, {29'd0, addr_i}, 3);
                n   = n + 3;
            end
        end
        // Pair mode: drop an unpaired tail bit (it stays below the sent window).
        n_send     = (ctrl_i.mode == DL_QUAD) ? (n & ~32'd1) : n;
        aligned    = acc << (FRAME_MAX - n);
        overflow_o = (n_send > BUF_BITS);
        frame_o    = aligned[FRAME_MAX-1 -: BUF_BITS];
        len_o      = overflow_o ? '0 : LEN_W'(n_send);
    end
endmodule

// File: rtl/dlf_bit_shifter.sv
module dlf_bit_shifter #(
    parameter  int BUF_BITS = 80,
    localparam int LEN_W    = $clog2(BUF_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [BUF_BITS-1:0] frame_i,
    input  logic [LEN_W-1:0]    len_i,
    input  logic                adv_i,
    output logic                bit_o,
    output logic                last_o
);
    logic [BUF_BITS-1:0] sreg_q;
    logic [LEN_W-1:0]    left_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
            left_q <= '0;
        end else if (load_i) begin
            sreg_q <= frame_i;
            left_q <= len_i;
        end else if (adv_i) begin
            sreg_q <= sreg_q << 1;
            left_q <= left_q - 1'b1;
        end
    end

    assign bit_o  = sreg_q[BUF_BITS-1];
    assign last_o = (left_q == LEN_W'(1));

    AST_ADV_HAS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |-> (left_q != '0)); // R7
endmodule

// File: rtl/dlf_frame_assembler.sv
module dlf_frame_assembler
    import dlf_pkg::*;
#(
    parameter  int BUF_BITS = 80,
    localparam int LEN_W    = $clog2(BUF_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [7:0]       ctrl_i,
    input  logic [31:0]      pwd_i,
    input  logic [31:0]      wdata_i,
    input  logic [2:0]       addr_i,
    output logic             bit_o,
    output logic             bit_valid_o,
    input  logic             bit_ready_i,
    output logic [LEN_W-1:0] frame_len_o,
    output logic [1:0]       mode_o,
    output logic             done_o,
    output logic             err_o
);
    dl_ctrl_t            ctrl;
    logic [BUF_BITS-1:0] pk_frame;
    logic [LEN_W-1:0]    pk_len;
    logic                pk_over;
    logic                take_start;
    logic                load;
    logic                accept;
    logic                last_bit;
    dlf_state_e          state_q;
    dlf_state_e          state_d;

    assign ctrl = ctrl_i;

    dlf_field_packer #(.BUF_BITS(BUF_BITS)) u_packer (
        .ctrl_i     (ctrl),
        .pwd_i      (pwd_i),
        .wdata_i    (wdata_i),
        .addr_i     (addr_i),
        .frame_o    (pk_frame),
        .len_o      (pk_len),
        .overflow_o (pk_over)
    );

    dlf_bit_shifter #(.BUF_BITS(BUF_BITS)) u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .frame_i (pk_frame),
        .len_i   (pk_len),
        .adv_i   (accept),
        .bit_o   (bit_o),
        .last_o  (last_bit)
    );

    assign take_start = (state_q == ST_IDLE) && start_i;
    assign load       = take_start && !pk_over;
    assign accept     = bit_valid_o && bit_ready_i;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (load) state_d = ST_SEND;
            ST_SEND:   if (accept && last_bit) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs decoded from state
    always_comb begin
        bit_valid_o = (state_q == ST_SEND);
        done_o      = (state_q == ST_FINISH);
    end

    // Per-frame registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_len_o <= '0;
            mode_o      <= 2'd0;
            err_o       <= 1'b0;
        end else begin
            err_o <= take_start && pk_over;
            if (load) begin
                frame_len_o <= pk_len;
                mode_o      <= ctrl.mode;
            end
        end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid_o && !bit_ready_i) |=> (bit_valid_o && $stable(bit_o))); // R8
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
    AST_ERR_NO_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !bit_valid_o); // R10
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (int'(pk_len) <= BUF_BITS)); // R10
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid_o |=> ($stable(mode_o) && $stable(frame_len_o))); // R7
    AST_QUAD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (load && ctrl.mode == DL_QUAD) |-> !pk_len[0]); // R11
endmodule

// File: tb/dlf_frame_assembler_tb.sv
module dlf_frame_assembler_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SMALL_BUF  = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  ctrl = 8'd0;
    logic [31:0] pwd = 32'd0;
    logic [31:0] wdata = 32'd0;
    logic [2:0]  addr = 3'd0;
    logic        bit_ready = 1'b1;
    logic        stall_en = 1'b0;
    logic [7:0]  lfsr = 8'hA5;

    logic        bit_o, bit_valid, done, err;
    logic [6:0]  frame_len;
    logic [1:0]  mode;
    logic        s_bit, s_valid, s_done, s_err;
    logic [5:0]  s_len;
    logic [1:0]  s_mode;

    int    checks = 0;
    int    failures = 0;
    int    cyc = 0;
    bit    exp_q[$];
    string cur_tag = "R1";
    bit    last_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dlf_frame_assembler u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .ctrl_i(ctrl), .pwd_i(pwd),
        .wdata_i(wdata), .addr_i(addr), .bit_o(bit_o), .bit_valid_o(bit_valid),
        .bit_ready_i(bit_ready), .frame_len_o(frame_len), .mode_o(mode),
        .done_o(done), .err_o(err)
    );

    // Same commands into a smaller buffer to reach the oversize path (R10)
    dlf_frame_assembler #(.BUF_BITS(SMALL_BUF)) u_small (
        .clk(clk), .rst_n(rst_n), .start_i(start), .ctrl_i(ctrl), .pwd_i(pwd),
        .wdata_i(wdata), .addr_i(addr), .bit_o(s_bit), .bit_valid_o(s_valid),
        .bit_ready_i(bit_ready), .frame_len_o(s_len), .mode_o(s_mode),
        .done_o(s_done), .err_o(s_err)
    );

    always @(posedge clk) begin
        lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        bit_ready <= stall_en ? (lfsr[0] | lfsr[3]) : 1'b1;
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Scoreboard monitor: pops expected bits as the design hands them off
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) chk(last_prev, "R9 done without last bit", 1, 0);
            last_prev = 1'b0;
            if (bit_valid && bit_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, {cur_tag, " unexpected bit"}, int'(bit_o), -1);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    chk(bit_o === e, {cur_tag, " R8 bit"}, int'(bit_o), int'(e));
                end
                if (exp_q.size() == 0) last_prev = 1'b1;
            end
        end
    end

    task automatic push_field(input logic [31:0] v, input int w);
        for (int i = w - 1; i >= 0; i--) exp_q.push_back(v[i]);
    endtask

    // Reference model from the requirements (R2..R6, R11)
    task automatic build_exp(input logic [7:0] c, input logic [31:0] p,
                             input logic [31:0] d, input logic [2:0] a);
        logic [1:0] m;
        m = c[4:3];
        exp_q.delete();
        if (m >= 2'd2) push_field(32'd0, 1);               // R2
        if (m == 2'd3) push_field(32'd0, 1);
        if (c[7]) push_field(32'd0, 2);                     // R3
        else begin
            if (c[2]) push_field(32'd1, 2);                 // R4
            else      push_field({30'd0, 1'b1, c[1]}, 2);
            if (c[0]) begin                                 // R5
                if (m >= 2'd2) push_field(32'd0, 2);
                push_field(p, 32);
            end
            if (!c[5]) push_field(32'd0, 1);                // R6
            if (!c[6]) push_field(d, 32);
            if (!c[5]) push_field({29'd0, a}, 3);
        end
        if (m == 2'd3 && (exp_q.size() % 2) == 1) void'(exp_q.pop_back()); // R11
    endtask

    task automatic run_frame(input logic [7:0] c, input logic [31:0] p,
                             input logic [31:0] d, input logic [2:0] a,
                             input string tag, input bit poke_busy);
        int exp_len;
        build_exp(c, p, d, a);
        exp_len = exp_q.size();
        cur_tag = tag;
        @(negedge clk);
        ctrl = c; pwd = p; wdata = d; addr = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(int'(frame_len) == exp_len, {tag, " R7 frame_len"}, int'(frame_len), exp_len);
        chk(mode == c[4:3], {tag, " R7 mode"}, int'(mode), int'(c[4:3]));
        chk(s_err == (exp_len > SMALL_BUF), {tag, " R10 err"}, int'(s_err), int'(exp_len > SMALL_BUF));
        if (exp_len > SMALL_BUF) chk(!s_valid, "R10 no bits after err", int'(s_valid), 0);
        if (c[4:3] == 2'd3) chk(frame_len[0] == 1'b0, "R11 even length", int'(frame_len), exp_len);
        if (poke_busy) begin
            repeat (4) @(negedge clk);
            ctrl = 8'h98; start = 1'b1;   // reset command, mode 3: must be ignored
            @(negedge clk);
            start = 1'b0;
            chk(mode == c[4:3], "R9 start ignored while busy", int'(mode), int'(c[4:3]));
        end
        while (!done) @(negedge clk);
        chk(exp_q.size() == 0, {tag, " R9 all bits before done"}, exp_q.size(), 0);
        @(negedge clk);
        chk(!done && !bit_valid, "R9 done single cycle", int'(done), 0);
        chk(mode == c[4:3], "R7 mode held after frame", int'(mode), int'(c[4:3]));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!bit_valid && !done && !err, "R1 flags in reset", int'({bit_valid, done, err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bit_valid && !done && !err, "R1 flags after reset", int'({bit_valid, done, err}), 0);
        chk(frame_len == 0 && mode == 0, "R1 len/mode after reset", int'(frame_len), 0);

        // Fixed mode write, page 0: opcode 10, lock, data, addr (R4, R6)
        run_frame(8'h00, 32'h0, 32'hA5C3_0F1E, 3'd5, "R4/R6", 1'b0);
        stall_en = 1'b1;
        // Fixed mode, password, page 1 (R5), oversize on small buffer (R10)
        run_frame(8'h03, 32'h8123_4567, 32'h1357_9BDF, 3'd2, "R5/R10", 1'b1);
        // Long reference mode read with password: no data (R6)
        run_frame(8'h49, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 3'd7, "R6", 1'b0);
        // Leading zero, register read + read, password with 00 prefix (R2, R5)
        run_frame(8'h71, 32'hC001_D00D, 32'h0, 3'd3, "R2/R5", 1'b0);
        // One-of-four write with password: longest frame (R2, R5, R11)
        run_frame(8'h19, 32'h5A5A_A5A5, 32'h0F0F_F0F0, 3'd6, "R2/R11", 1'b0);
        // One-of-four reset (R3)
        run_frame(8'h98, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd7, "R3", 1'b0);
        stall_en = 1'b0;
        // Leading zero, test-mode write (R4)
        run_frame(8'h14, 32'h0, 32'h8000_0001, 3'd1, "R4", 1'b0);
        // Long reference reset (R3)
        run_frame(8'h88, 32'h0, 32'h0, 3'd0, "R3", 1'b0);
        // One-of-four read, no password (R2, R6)
        run_frame(8'h5A, 32'h0, 32'hFFFF_FFFF, 3'd4, "R2/R6", 1'b0);
        finish_run();
    end
endmodule